// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a decoded memory-operand descriptor into the address a load/store unit puts on the bus. It receives the two-bit addressing mode and the three-bit operand-select field of an instruction, a 16-bit displacement, an optional segment-override prefix byte and the current contents of the base, index, pointer and segment registers. From these it forms a 16-bit effective address (the offset within a segment), names the segment used, and builds the 20-bit physical address. The segment value is shifted left by four bits and the offset is added to it.

Besides ordinary data operands, the block serves three fixed access kinds: instruction fetch (code segment with the instruction pointer), stack push/pop (stack segment with the stack pointer) and string destinations (extra segment with the destination index). A single-cycle strobe launches a computation. The result and a valid flag appear on registered outputs one clock later. A register-operand encoding raises a flag instead of producing an address, and the address outputs keep their old values.

Control is a three-state machine. ST_IDLE means no result is presented. ST_MEM means a memory address is presented. ST_REG means the last request named a register operand. From any state, a strobe moves the machine to ST_REG if the request is a data access with mode 11. Any other strobe moves it to ST_MEM. A clock edge with no strobe returns it to ST_IDLE.

Top module: `seg_ea_gen`

## Requirements
- R1: After reset, out_valid and is_reg are 0, eff_addr and phys_addr are 0, and seg_sel is 0.
- R2: out_valid is 1 in exactly the cycle after each cycle in which req_valid is 1, and 0 otherwise. Back-to-back strobes give back-to-back results.
- R3: For data accesses (acc_kind 00) the operand-select field picks the offset terms. 000 is BX+SI, 001 is BX+DI, 010 is BP+SI, 011 is BP+DI, 100 is SI, 101 is DI, 110 is BP and 111 is BX. Mode 00 adds no displacement.
- R4: Without an override, operand selects 010, 011 and 110 use the stack segment and all other memory forms use the data segment. seg_sel encodes ES=0, CS=1, SS=2, DS=3.
- R5: Mode 00 with operand select 110 is a direct address. The effective address is the full displacement and the segment is DS.
- R6: Mode 01 adds disp[7:0] sign-extended to 16 bits. disp[15:8] has no effect.
- R7: Mode 10 adds the full 16-bit displacement.
- R8: The effective-address sum wraps modulo 2^16.
- R9: phys_addr equals (segment value × 16 + eff_addr) modulo 2^20.
- R10: A data request with mode 11 sets is_reg to 1 with out_valid. eff_addr, seg_sel and phys_addr keep their previous values.
- R11: acc_kind 01 (fetch) uses CS:IP, 10 (stack) uses SS:SP and 11 (string destination) uses ES:DI. For these kinds, mode and operand select are ignored and is_reg stays 0.
- R12: On a data access with ovr_valid set, prefix byte 26h selects ES, 2Eh selects CS, 36h selects SS and 3Eh selects DS. Any other byte leaves the default segment.
- R13: Overrides are ignored for fetch, stack and string-destination accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Strobe launching one address computation |
| acc_kind | input | 2 | 00 data, 01 fetch, 10 stack, 11 string destination |
| mode | input | 2 | Addressing mode field |
| rm_sel | input | 3 | Operand-select field |
| disp | input | 16 | Displacement or direct address |
| ovr_valid | input | 1 | Segment-override prefix present |
| ovr_code | input | 8 | Override prefix byte |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base pointer BP |
| reg_si | input | 16 | Source index SI |
| reg_di | input | 16 | Destination index DI |
| reg_sp | input | 16 | Stack pointer |
| reg_ip | input | 16 | Instruction pointer |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| out_valid | output | 1 | Result presented this cycle |
| is_reg | output | 1 | Last request named a register operand |
| eff_addr | output | 16 | Effective address |
| seg_sel | output | 2 | Segment used (ES=0, CS=1, SS=2, DS=3) |
| phys_addr | output | 20 | Physical address |

## Verification
The bench walks every operand-select encoding and checks both the offset and the default segment. This exposes a design that swaps a base or index term, or that sends BP-based forms to DS. The mode-00/select-110 direct case is checked against the BP form with a displacement: a design that misses the exception would add BP and pick SS. An 8-bit displacement with its top bit set is used to catch zero-extension, and garbage in the high byte is used to catch a full-width add. Offset and physical sums that overflow are used to catch a carry leaking into a wider result. Override bytes are applied to data, fetch, stack and string accesses, along with an unknown byte, to find an override that leaks into fixed-segment kinds. A register-operand request after a memory request shows whether the address outputs are overwritten.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ACC_DATA   = 2'd0,
        ACC_FETCH  = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_REG  = 2'd2
    } st_e;

    localparam logic [7:0] PFX_ES = 8'h26;
    localparam logic [7:0] PFX_CS = 8'h2E;
    localparam logic [7:0] PFX_SS = 8'h36;
    localparam logic [7:0] PFX_DS = 8'h3E;

    localparam logic [1:0] MODE_REG = 2'b11;

endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
    import seg_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int SHORT_W = 8
) (
    input  logic [1:0]    mode,
    input  logic [2:0]    rm_sel,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] reg_bx,
    input  logic [AW-1:0] reg_bp,
    input  logic [AW-1:0] reg_si,
    input  logic [AW-1:0] reg_di,
    output logic [AW-1:0] ea,
    output seg_e          def_seg
);
    localparam int EXT_W = AW - SHORT_W;

    logic [AW-1:0] base_t;
    logic [AW-1:0] index_t;
    logic [AW-1:0] disp_t;
    logic          direct;

    assign direct = (mode == 2'b00) && (rm_sel == 3'b110);

    always_comb begin
        base_t  = '0;
        index_t = '0;
        unique case (rm_sel)
            3'b000: begin base_t = reg_bx; index_t = reg_si; end
            3'b001: begin base_t = reg_bx; index_t = reg_di; end
            3'b010: begin base_t = reg_bp; index_t = reg_si; end
            3'b011: begin base_t = reg_bp; index_t = reg_di; end
            3'b100: index_t = reg_si;
            3'b101: index_t = reg_di;
            3'b110: base_t  = reg_bp;
            3'b111: base_t  = reg_bx;
            default: base_t = '0;
        endcase
    end

    always_comb begin
        unique case (mode)
            2'b01:   disp_t = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
            2'b10:   disp_t = disp;
            default: disp_t = '0;
        endcase
    end

    always_comb begin
        if (direct) begin
            ea      = disp;
            def_seg = SEG_DS;
        end else begin
            ea = base_t + index_t + disp_t;
            if (rm_sel == 3'b010 || rm_sel == 3'b011 || rm_sel == 3'b110)
                def_seg = SEG_SS;
            else
                def_seg = SEG_DS;
        end
    end

endmodule

// File: rtl/seg_resolve.sv
module seg_resolve
    import seg_ea_pkg::*;
(
    input  acc_e       kind,
    input  seg_e       def_seg,
    input  logic       ovr_valid,
    input  logic [7:0] ovr_code,
    output seg_e       seg_sel
);
    seg_e ovr_seg;
    logic ovr_hit;

    always_comb begin
        ovr_hit = ovr_valid;
        ovr_seg = SEG_DS;
        unique case (ovr_code)
            PFX_ES:  ovr_seg = SEG_ES;
            PFX_CS:  ovr_seg = SEG_CS;
            PFX_SS:  ovr_seg = SEG_SS;
            PFX_DS:  ovr_seg = SEG_DS;
            default: ovr_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (kind)
            ACC_FETCH:  seg_sel = SEG_CS;
            ACC_STACK:  seg_sel = SEG_SS;
            ACC_STRDST: seg_sel = SEG_ES;
            default:    seg_sel = ovr_hit ? ovr_seg : def_seg;
        endcase
    end

endmodule

// File: rtl/phys_form.sv
module phys_form #(
    parameter int AW = 16,
    parameter int PW = 20
) (
    input  logic [AW-1:0] seg_val,
    input  logic [AW-1:0] off,
    output logic [PW-1:0] phys
);
    localparam int SH = PW - AW;

    generate
        if (SH > 0) begin : g_shift
            assign phys = {seg_val, {SH{1'b0}}} + {{SH{1'b0}}, off};
        end else begin : g_flat
            assign phys = seg_val[PW-1:0] + off[PW-1:0];
        end
    endgenerate

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import seg_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    acc_kind,
    input  logic [1:0]    mode,
    input  logic [2:0]    rm_sel,
    input  logic [AW-1:0] disp,
    input  logic          ovr_valid,
    input  logic [7:0]    ovr_code,
    input  logic [AW-1:0] reg_bx,
    input  logic [AW-1:0] reg_bp,
    input  logic [AW-1:0] reg_si,
    input  logic [AW-1:0] reg_di,
    input  logic [AW-1:0] reg_sp,
    input  logic [AW-1:0] reg_ip,
    input  logic [AW-1:0] seg_es,
    input  logic [AW-1:0] seg_cs,
    input  logic [AW-1:0] seg_ss,
    input  logic [AW-1:0] seg_ds,
    output logic          out_valid,
    output logic          is_reg,
    output logic [AW-1:0] eff_addr,
    output logic [1:0]    seg_sel,
    output logic [PW-1:0] phys_addr
);
    acc_e          kind;
    seg_e          def_seg;
    seg_e          seg_c;
    logic [AW-1:0] mem_ea;
    logic [AW-1:0] ea_c;
    logic [AW-1:0] seg_val_c;
    logic [PW-1:0] phys_c;
    logic          reg_req;
    st_e           state_q;
    st_e           state_d;
    logic [AW-1:0] ea_q;
    seg_e          seg_q;
    logic [PW-1:0] phys_q;

    assign kind    = acc_e'(acc_kind);
    assign reg_req = (kind == ACC_DATA) && (mode == MODE_REG);

    ea_offset_calc #(.AW(AW)) u_off (
        .mode    (mode),
        .rm_sel  (rm_sel),
        .disp    (disp),
        .reg_bx  (reg_bx),
        .reg_bp  (reg_bp),
        .reg_si  (reg_si),
        .reg_di  (reg_di),
        .ea      (mem_ea),
        .def_seg (def_seg)
    );

    seg_resolve u_seg (
        .kind      (kind),
        .def_seg   (def_seg),
        .ovr_valid (ovr_valid),
        .ovr_code  (ovr_code),
        .seg_sel   (seg_c)
    );

    always_comb begin
        unique case (kind)
            ACC_FETCH:  ea_c = reg_ip;
            ACC_STACK:  ea_c = reg_sp;
            ACC_STRDST: ea_c = reg_di;
            default:    ea_c = mem_ea;
        endcase
    end

    always_comb begin
        unique case (seg_c)
            SEG_ES:  seg_val_c = seg_es;
            SEG_CS:  seg_val_c = seg_cs;
            SEG_SS:  seg_val_c = seg_ss;
            default: seg_val_c = seg_ds;
        endcase
    end

    phys_form #(.AW(AW), .PW(PW)) u_phys (
        .seg_val (seg_val_c),
        .off     (ea_c),
        .phys    (phys_c)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_MEM, ST_REG: begin
                if (req_valid)
                    state_d = reg_req ? ST_REG : ST_MEM;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q   <= '0;
            seg_q  <= SEG_ES;
            phys_q <= '0;
        end else if (req_valid && !reg_req) begin
            ea_q   <= ea_c;
            seg_q  <= seg_c;
            phys_q <= phys_c;
        end
    end

    assign out_valid = (state_q != ST_IDLE);
    assign is_reg    = (state_q == ST_REG);
    assign eff_addr  = ea_q;
    assign seg_sel   = seg_q;
    assign phys_addr = phys_q;

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_NO_VALID_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2
    AST_REG_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd0 && mode == 2'b11) |=>
            (is_reg && $stable(eff_addr) && $stable(phys_addr) && $stable(seg_sel))); // R10
    AST_FIXED_KIND_NOT_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind != 2'd0) |=> !is_reg); // R11
    AST_FETCH_USES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd1) |=> (seg_sel == 2'd1 && eff_addr == $past(reg_ip))); // R13
    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd0 && mode == 2'b00 && rm_sel == 3'b110 && !ovr_valid) |=>
            (eff_addr == $past(disp) && seg_sel == 2'd3)); // R5
    AST_BP_FORMS_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd0 && !ovr_valid && mode != 2'b11 &&
         (rm_sel == 3'b010 || rm_sel == 3'b011 || (rm_sel == 3'b110 && mode != 2'b00))) |=>
            (seg_sel == 2'd2)); // R4

endmodule

// File: tb/seg_ea_gen_tb.sv
module seg_ea_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  mode = '0;
    logic [2:0]  rm_sel = '0;
    logic [15:0] disp = '0;
    logic        ovr_valid = 1'b0;
    logic [7:0]  ovr_code = '0;
    logic [15:0] reg_bx = 16'h0300, reg_bp = 16'h0500, reg_si = 16'h0200, reg_di = 16'h0400;
    logic [15:0] reg_sp = 16'h0300, reg_ip = 16'h0110;
    logic [15:0] seg_es = 16'hFFF0, seg_cs = 16'h0400, seg_ss = 16'h0100, seg_ds = 16'h0200;
    logic        out_valid, is_reg;
    logic [15:0] eff_addr;
    logic [1:0]  seg_sel;
    logic [19:0] phys_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_ea_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
        .mode(mode), .rm_sel(rm_sel), .disp(disp), .ovr_valid(ovr_valid),
        .ovr_code(ovr_code), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
        .reg_di(reg_di), .reg_sp(reg_sp), .reg_ip(reg_ip), .seg_es(seg_es),
        .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds), .out_valid(out_valid),
        .is_reg(is_reg), .eff_addr(eff_addr), .seg_sel(seg_sel), .phys_addr(phys_addr)
    );

    // kind, mode, rm, disp, ovr_v, ovr_code, exp_ea, exp_seg, exp_phys
    localparam int NV = 22;
    localparam logic [69:0] VECS [NV] = '{
        {2'd0, 2'd0, 3'd0, 16'h0000, 1'b0, 8'h00, 16'h0500, 2'd3, 20'h02500}, // R3 R9
        {2'd0, 2'd0, 3'd1, 16'h0000, 1'b0, 8'h00, 16'h0700, 2'd3, 20'h02700}, // R3
        {2'd0, 2'd0, 3'd2, 16'h0000, 1'b0, 8'h00, 16'h0700, 2'd2, 20'h01700}, // R3 R4
        {2'd0, 2'd0, 3'd3, 16'h0000, 1'b0, 8'h00, 16'h0900, 2'd2, 20'h01900}, // R3 R4
        {2'd0, 2'd0, 3'd4, 16'h0000, 1'b0, 8'h00, 16'h0200, 2'd3, 20'h02200}, // R3
        {2'd0, 2'd0, 3'd5, 16'h0000, 1'b0, 8'h00, 16'h0400, 2'd3, 20'h02400}, // R3
        {2'd0, 2'd0, 3'd6, 16'h1234, 1'b0, 8'h00, 16'h1234, 2'd3, 20'h03234}, // R5
        {2'd0, 2'd0, 3'd7, 16'h0000, 1'b0, 8'h00, 16'h0300, 2'd3, 20'h02300}, // R3
        {2'd0, 2'd1, 3'd6, 16'h00F0, 1'b0, 8'h00, 16'h04F0, 2'd2, 20'h014F0}, // R6 R4
        {2'd0, 2'd1, 3'd4, 16'hAB10, 1'b0, 8'h00, 16'h0210, 2'd3, 20'h02210}, // R6
        {2'd0, 2'd2, 3'd5, 16'h0250, 1'b0, 8'h00, 16'h0650, 2'd3, 20'h02650}, // R7
        {2'd0, 2'd2, 3'd3, 16'hFFFF, 1'b0, 8'h00, 16'h08FF, 2'd2, 20'h018FF}, // R8
        {2'd0, 2'd2, 3'd7, 16'hF000, 1'b0, 8'h00, 16'hF300, 2'd3, 20'h11300}, // R7 R9
        {2'd3, 2'd0, 3'd0, 16'h0000, 1'b0, 8'h00, 16'h0400, 2'd0, 20'h00300}, // R11 R9
        {2'd1, 2'd3, 3'd2, 16'h5555, 1'b1, 8'h3E, 16'h0110, 2'd1, 20'h04110}, // R11 R13
        {2'd2, 2'd1, 3'd7, 16'h0000, 1'b1, 8'h26, 16'h0300, 2'd2, 20'h01300}, // R11 R13
        {2'd0, 2'd0, 3'd0, 16'h0000, 1'b1, 8'h26, 16'h0500, 2'd0, 20'h00400}, // R12 R9
        {2'd0, 2'd0, 3'd7, 16'h0000, 1'b1, 8'h2E, 16'h0300, 2'd1, 20'h04300}, // R12
        {2'd0, 2'd0, 3'd4, 16'h0000, 1'b1, 8'h36, 16'h0200, 2'd2, 20'h01200}, // R12
        {2'd0, 2'd0, 3'd2, 16'h0000, 1'b1, 8'h3E, 16'h0700, 2'd3, 20'h02700}, // R12
        {2'd0, 2'd0, 3'd2, 16'h0000, 1'b1, 8'h55, 16'h0700, 2'd2, 20'h01700}, // R12
        {2'd3, 2'd2, 3'd1, 16'h0000, 1'b1, 8'h36, 16'h0400, 2'd0, 20'h00300}  // R13
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [69:0] v);
        acc_kind  = v[69:68];
        mode      = v[67:66];
        rm_sel    = v[65:63];
        disp      = v[62:47];
        ovr_valid = v[46];
        ovr_code  = v[45:38];
        req_valid = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] held_phys;
        logic [15:0] held_ea;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 is_reg", 32'(is_reg), 0);
        chk("R1 eff_addr", 32'(eff_addr), 0);
        chk("R1 phys_addr", 32'(phys_addr), 0);
        chk("R1 seg_sel", 32'(seg_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            req_valid = 1'b0;
            chk($sformatf("R2 vec%0d out_valid", i), 32'(out_valid), 1);
            chk($sformatf("R11 vec%0d is_reg", i), 32'(is_reg), 0);
            chk($sformatf("R3 vec%0d eff_addr", i), 32'(eff_addr), 32'(VECS[i][37:22]));
            chk($sformatf("R4 vec%0d seg_sel", i), 32'(seg_sel), 32'(VECS[i][21:20]));
            chk($sformatf("R9 vec%0d phys_addr", i), 32'(phys_addr), 32'(VECS[i][19:0]));
        end

        // R2: no strobe -> valid drops
        @(negedge clk);
        chk("R2 idle out_valid", 32'(out_valid), 0);

        // R10: register operand after a memory request keeps address outputs
        drive(VECS[0]);
        @(negedge clk);
        held_ea = eff_addr;
        held_phys = phys_addr;
        drive({2'd0, 2'd3, 3'd5, 16'h7777, 1'b1, 8'h26, 16'h0, 2'd0, 20'h0});
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 out_valid", 32'(out_valid), 1);
        chk("R10 is_reg", 32'(is_reg), 1);
        chk("R10 eff_addr held", 32'(eff_addr), 32'(held_ea));
        chk("R10 phys_addr held", 32'(phys_addr), 32'(held_phys));
        chk("R10 seg_sel held", 32'(seg_sel), 3);

        // R2: back-to-back strobes, second result follows
        drive(VECS[6]);
        @(negedge clk);
        chk("R2 b2b first phys", 32'(phys_addr), 32'h03234);
        drive(VECS[10]);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 b2b out_valid", 32'(out_valid), 1);
        chk("R2 b2b is_reg cleared", 32'(is_reg), 0);
        chk("R7 b2b phys", 32'(phys_addr), 32'h02650);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rerst out_valid", 32'(out_valid), 0);
        chk("R1 rerst phys_addr", 32'(phys_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule